// File: doc/BRIEF.md
# USB Host Controller Register File

This block is the software-visible register window of a USB 1.x host controller with a two-port root hub. It decodes byte and word accesses on a simple register bus. Behind that decode it keeps the command, status and interrupt-enable registers, the frame number, the frame list base address, the start-of-frame timing byte and one status/control register per root-hub port. Software uses it to start and stop the controller, reset the controller or the whole bus, and enable, reset and watch each port.

Hardware events enter on side inputs. The schedule engine reports transfer completion, transfer error and process error. The port transceivers report device attach and detach, with a speed flag per port. The block turns these into latched change bits, resume signalling while the bus is globally suspended, and a level interrupt. A port's reset strobe and the global reset strobe are one-cycle pulses for the hub and device logic.

Reads are combinational from the address. A write takes effect at the clock edge on which `req_i` and `we_i` are high, and it is visible on `rdata_o` and the status outputs right after that edge.

Top module: `uhc_regs`

## Requirements
- R1: Only the low 5 address bits are decoded. A byte read returns the start-of-frame byte (zero-extended) at offset 0x0C and 0x00FF at any other offset. A word read of an unmapped offset returns 0x00FF. A byte write to any offset other than 0x0C is ignored.
- R2: After reset, the registers read as follows: command (0x00) 0x0000, status (0x02) 0x0020, interrupt enable (0x04) 0x0000, frame number (0x06) 0, base low (0x08) 0, base high (0x0A) 0, start-of-frame byte 0x40, ports 0x0080. The outputs are `run_o`=0, `halted_o`=1, `irq_o`=0, and both strobes are low.
- R3: Command bit 0 is run. Writing it 1 while it was 0 clears halted (status bit 5). Writing it 0 sets halted. Writing it 1 while already 1 leaves halted unchanged. `run_o` follows the stored bit.
- R4: Writing command bit 1 (controller reset) or bit 2 (global reset) returns every register to its reset value, except that each port keeps its connect (bit 0) and low-speed (bit 8) bits. Both reset bits read back 0. A global reset also pulses `glob_rst_o` and pulses `port_rst_o` for every connected port, in the cycle after the write. A controller reset pulses neither.
- R5: Offsets 0x10 to 0x1F select port (offset >> 1) & 7. An index at or above the port count reads 0x00FF and ignores writes.
- R6: A port write keeps the old value of the bits under mask 0x01FB and takes all other bits from the written data. Writing 1 to connect-change (bit 1) or enable-change (bit 3) clears that bit. Bit 2 is enable, bit 7 always reads 1, and bit 9 is port reset.
- R7: Writing port bit 9 from 0 to 1 while the port is connected pulses that port's `port_rst_o` bit for one cycle after the write. A write that leaves bit 9 at 1 gives no pulse.
- R8: On attach, bits 0 and 1 are set and bit 8 takes `low_speed_i`. On detach of a connected port, bit 0 clears and bit 1 sets. If the port is enabled at that point, including by a write in the same cycle, bit 2 clears and bit 3 sets. An event overrides a write to the same bits in the same cycle.
- R9: On any attach or detach while command bit 3 (global suspend) is set, command bit 4 (force resume) and status bit 2 (resume detect) are set. With bit 3 clear, an attach or detach changes neither register.
- R10: Status bits 0, 1 and 4 are set by `evt_i[0]`, `evt_i[1]` and `evt_i[2]`. Status bits 0 to 4 are cleared by writing 1. A hardware set in the same cycle as a clear wins.
- R11: `irq_o` is high while any of these pairs has both bits set: status bit 1 with enable bit 0, status bit 2 with enable bit 1, status bit 0 with enable bit 2, status bit 4 with enable bit 3. Only enable bits 3:0 are stored.
- R12: The frame number stores 11 bits. The frame list base stores address bits 31:12: base-low offset 0x08 holds bits 15:12 in its top nibble, and offset 0x0A holds bits 31:16. The start-of-frame byte is written only by a byte write to 0x0C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access strobe, qualifies writes |
| we_i | input | 1 | Write when high |
| byte_i | input | 1 | Byte access when high, word access when low |
| addr_i | input | ADDR_W | Register address, low 5 bits decoded |
| wdata_i | input | 16 | Write data; byte writes use bits 7:0 |
| rdata_o | output | 16 | Read data for the current address and size |
| evt_i | input | 3 | Schedule events: done, error, process error |
| attach_i | input | NPORTS | Device attach event per port |
| detach_i | input | NPORTS | Device detach event per port |
| low_speed_i | input | NPORTS | Speed flag sampled on attach |
| irq_o | output | 1 | Level interrupt |
| run_o | output | 1 | Controller running |
| halted_o | output | 1 | Controller halted |
| glob_rst_o | output | 1 | One-cycle global bus reset strobe |
| port_rst_o | output | NPORTS | One-cycle reset strobe per port |

## Verification
Two updates can land on the same register bit in the same clock cycle. One is a software write: a clear-by-writing-one on a change bit, or an enable write. The other is a hardware event from a port or from the schedule engine. The bench forces this by raising `attach_i` or `detach_i` at the same falling edge that presents a port write or status write. It then reads the register back and checks that the event's effect survives: the change bit is still set, and the connect, speed and enable state follow the event. A global reset with one port connected and one not is checked the same way, by sampling both strobe outputs right after the write.

// File: rtl/uhc_pkg.sv
package uhc_pkg;
  localparam int unsigned OFS_W   = 5;
  localparam int unsigned DW      = 16;
  localparam int unsigned CMD_W   = 8;
  localparam int unsigned STS_W   = 6;
  localparam int unsigned IEN_W   = 4;
  localparam int unsigned FNUM_W  = 11;
  localparam int unsigned FBASE_W = 20;
  localparam int unsigned SOF_W   = 8;
  localparam int unsigned EVT_W   = 3;

  localparam logic [OFS_W-1:0] OFS_CMD  = 5'h00;
  localparam logic [OFS_W-1:0] OFS_STS  = 5'h02;
  localparam logic [OFS_W-1:0] OFS_IEN  = 5'h04;
  localparam logic [OFS_W-1:0] OFS_FNUM = 5'h06;
  localparam logic [OFS_W-1:0] OFS_FBLO = 5'h08;
  localparam logic [OFS_W-1:0] OFS_FBHI = 5'h0A;
  localparam logic [OFS_W-1:0] OFS_SOF  = 5'h0C;

  // command bits
  localparam int unsigned C_RUN  = 0;
  localparam int unsigned C_HRST = 1;
  localparam int unsigned C_GRST = 2;
  localparam int unsigned C_SUSP = 3;
  localparam int unsigned C_FRES = 4;

  // status bits
  localparam int unsigned S_DONE = 0;
  localparam int unsigned S_ERR  = 1;
  localparam int unsigned S_RES  = 2;
  localparam int unsigned S_PERR = 4;
  localparam int unsigned S_HALT = 5;

  // port bits
  localparam int unsigned P_CCS = 0;
  localparam int unsigned P_CSC = 1;
  localparam int unsigned P_EN  = 2;
  localparam int unsigned P_ENC = 3;
  localparam int unsigned P_LS  = 8;
  localparam int unsigned P_RST = 9;

  localparam logic [DW-1:0] PORT_KEEP  = 16'h01FB;
  localparam logic [DW-1:0] PORT_W1C   = 16'h000A;
  localparam logic [DW-1:0] PORT_RSTV  = 16'h0080;
  localparam logic [DW-1:0] PORT_HOLD  = 16'h0101;
  localparam logic [DW-1:0] RD_DFLT    = 16'h00FF;
  localparam logic [STS_W-1:0] STS_RSTV = 6'h20;
  localparam logic [SOF_W-1:0] SOF_RSTV = 8'h40;
endpackage

// File: rtl/uhc_ctl.sv
module uhc_ctl
  import uhc_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               wr_cmd_i,
  input  logic               wr_sts_i,
  input  logic               wr_ien_i,
  input  logic [CMD_W-1:0]   wdata_i,
  input  logic [EVT_W-1:0]   evt_i,
  input  logic               wake_i,
  output logic [CMD_W-1:0]   cmd_o,
  output logic [STS_W-1:0]   sts_o,
  output logic [IEN_W-1:0]   ien_o,
  output logic               irq_o
);
  logic [CMD_W-1:0] cmd_q, cmd_d;
  logic [STS_W-1:0] sts_q, sts_d;
  logic [IEN_W-1:0] ien_q, ien_d;

  always_comb begin
    cmd_d = cmd_q;
    sts_d = sts_q;
    ien_d = ien_q;
    if (wr_cmd_i) begin
      cmd_d         = wdata_i;
      cmd_d[C_HRST] = 1'b0;
      cmd_d[C_GRST] = 1'b0;
      if (wdata_i[C_RUN] && !cmd_q[C_RUN]) sts_d[S_HALT] = 1'b0;
      else if (!wdata_i[C_RUN])            sts_d[S_HALT] = 1'b1;
    end
    if (wr_sts_i) sts_d[S_PERR:0] = sts_q[S_PERR:0] & ~wdata_i[S_PERR:0];
    if (wr_ien_i) ien_d = wdata_i[IEN_W-1:0];
    // hardware sets win over software clears
    if (evt_i[0]) sts_d[S_DONE] = 1'b1;
    if (evt_i[1]) sts_d[S_ERR]  = 1'b1;
    if (evt_i[2]) sts_d[S_PERR] = 1'b1;
    if (wake_i && cmd_q[C_SUSP]) begin
      cmd_d[C_FRES] = 1'b1;
      sts_d[S_RES]  = 1'b1;
    end
    sts_d[3] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= '0;
      sts_q <= STS_RSTV;
      ien_q <= '0;
    end else if (clr_i) begin
      cmd_q <= '0;
      sts_q <= STS_RSTV;
      ien_q <= '0;
    end else begin
      cmd_q <= cmd_d;
      sts_q <= sts_d;
      ien_q <= ien_d;
    end
  end

  assign irq_o = (sts_q[S_ERR]  & ien_q[0]) | (sts_q[S_RES]  & ien_q[1]) |
                 (sts_q[S_DONE] & ien_q[2]) | (sts_q[S_PERR] & ien_q[3]);
  assign cmd_o = cmd_q;
  assign sts_o = sts_q;
  assign ien_o = ien_q;

  a_r3_start_clears_halt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cmd_i && wdata_i[C_RUN] && !cmd_q[C_RUN] && !clr_i) |=> !sts_q[S_HALT]);
  a_r3_stop_sets_halt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cmd_i && !wdata_i[C_RUN]) |=> sts_q[S_HALT]);
  a_r9_resume_on_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_i && cmd_q[C_SUSP] && !clr_i) |=> (cmd_q[C_FRES] && sts_q[S_RES]));
  a_r10_event_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i[0] && !clr_i) |=> sts_q[S_DONE]);
  a_r10_w1c_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_sts_i && wdata_i[S_DONE] && !evt_i[0] && !clr_i) |=> !sts_q[S_DONE]);
endmodule

// File: rtl/uhc_frm.sv
module uhc_frm
  import uhc_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               wr_fnum_i,
  input  logic               wr_blo_i,
  input  logic               wr_bhi_i,
  input  logic               wr_sof_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [FNUM_W-1:0]  fnum_o,
  output logic [FBASE_W-1:0] fbase_o,
  output logic [SOF_W-1:0]   sof_o
);
  localparam int unsigned LO_W = DW - 12;

  logic [FNUM_W-1:0]  fnum_q;
  logic [FBASE_W-1:0] fbase_q;
  logic [SOF_W-1:0]   sof_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fnum_q  <= '0;
      fbase_q <= '0;
      sof_q   <= SOF_RSTV;
    end else if (clr_i) begin
      fnum_q  <= '0;
      fbase_q <= '0;
      sof_q   <= SOF_RSTV;
    end else begin
      if (wr_fnum_i) fnum_q <= wdata_i[FNUM_W-1:0];
      if (wr_blo_i)  fbase_q[LO_W-1:0] <= wdata_i[DW-1:12];
      if (wr_bhi_i)  fbase_q[FBASE_W-1:LO_W] <= wdata_i;
      if (wr_sof_i)  sof_q <= wdata_i[SOF_W-1:0];
    end
  end

  assign fnum_o  = fnum_q;
  assign fbase_o = fbase_q;
  assign sof_o   = sof_q;

  a_r12_fnum_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_fnum_i && !clr_i) |=> (fnum_q == $past(wdata_i[FNUM_W-1:0])));
endmodule

// File: rtl/uhc_port.sv
module uhc_port
  import uhc_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          glob_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          attach_i,
  input  logic          detach_i,
  input  logic          ls_i,
  output logic [DW-1:0] ctl_o,
  output logic          rst_pulse_o
);
  logic [DW-1:0] ctl_q, ctl_d;
  logic          pulse_q, pulse_d;

  always_comb begin
    ctl_d = ctl_q;
    if (clr_i) begin
      ctl_d = PORT_RSTV | (ctl_q & PORT_HOLD);
    end else if (wr_i) begin
      ctl_d = (ctl_q & PORT_KEEP) | (wdata_i & ~PORT_KEEP);
      ctl_d = ctl_d & ~(wdata_i & PORT_W1C);
    end
    if (attach_i) begin
      ctl_d[P_CCS] = 1'b1;
      ctl_d[P_CSC] = 1'b1;
      ctl_d[P_LS]  = ls_i;
    end else if (detach_i) begin
      if (ctl_d[P_CCS]) begin
        ctl_d[P_CCS] = 1'b0;
        ctl_d[P_CSC] = 1'b1;
      end
      if (ctl_d[P_EN]) begin
        ctl_d[P_EN]  = 1'b0;
        ctl_d[P_ENC] = 1'b1;
      end
    end
    pulse_d = ctl_q[P_CCS] &
              (glob_i | (wr_i & !clr_i & wdata_i[P_RST] & !ctl_q[P_RST]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q   <= PORT_RSTV;
      pulse_q <= 1'b0;
    end else begin
      ctl_q   <= ctl_d;
      pulse_q <= pulse_d;
    end
  end

  assign ctl_o       = ctl_q;
  assign rst_pulse_o = pulse_q;

  a_r6_keep_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !clr_i && !attach_i && !detach_i) |=>
      ((ctl_q & (PORT_KEEP & ~PORT_W1C)) == ($past(ctl_q) & (PORT_KEEP & ~PORT_W1C))));
  a_r8_attach_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    attach_i |=> (ctl_q[P_CCS] && ctl_q[P_CSC]));
  a_r8_detach_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (detach_i && !attach_i && ctl_q[P_CCS]) |=> (!ctl_q[P_CCS] && ctl_q[P_CSC]));
  a_r7_pulse_needs_conn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_pulse_o |-> $past(ctl_q[P_CCS]));
endmodule

// File: rtl/uhc_rdmux.sv
module uhc_rdmux
  import uhc_pkg::*;
#(
  parameter int unsigned NPORTS = 2
) (
  input  logic                 byte_i,
  input  logic [OFS_W-1:0]     ofs_i,
  input  logic [CMD_W-1:0]     cmd_i,
  input  logic [STS_W-1:0]     sts_i,
  input  logic [IEN_W-1:0]     ien_i,
  input  logic [FNUM_W-1:0]    fnum_i,
  input  logic [FBASE_W-1:0]   fbase_i,
  input  logic [SOF_W-1:0]     sof_i,
  input  logic [NPORTS*DW-1:0] ports_i,
  output logic [DW-1:0]        rdata_o
);
  localparam int unsigned LO_W = DW - 12;

  logic [DW-1:0] pword;

  always_comb begin
    pword = RD_DFLT;
    for (int i = 0; i < NPORTS; i++) begin
      if (ofs_i[3:1] == 3'(i)) pword = ports_i[i*DW +: DW];
    end
  end

  always_comb begin
    rdata_o = RD_DFLT;
    if (byte_i) begin
      if (ofs_i == OFS_SOF) rdata_o = {{(DW-SOF_W){1'b0}}, sof_i};
    end else begin
      unique case (ofs_i)
        OFS_CMD:  rdata_o = {{(DW-CMD_W){1'b0}}, cmd_i};
        OFS_STS:  rdata_o = {{(DW-STS_W){1'b0}}, sts_i};
        OFS_IEN:  rdata_o = {{(DW-IEN_W){1'b0}}, ien_i};
        OFS_FNUM: rdata_o = {{(DW-FNUM_W){1'b0}}, fnum_i};
        OFS_FBLO: rdata_o = {fbase_i[LO_W-1:0], 12'h000};
        OFS_FBHI: rdata_o = fbase_i[FBASE_W-1:LO_W];
        default:  if (ofs_i[4]) rdata_o = pword;
      endcase
    end
  end
endmodule

// File: rtl/uhc_regs.sv
module uhc_regs
  import uhc_pkg::*;
#(
  parameter int unsigned NPORTS = 2,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              byte_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic [EVT_W-1:0]  evt_i,
  input  logic [NPORTS-1:0] attach_i,
  input  logic [NPORTS-1:0] detach_i,
  input  logic [NPORTS-1:0] low_speed_i,
  output logic              irq_o,
  output logic              run_o,
  output logic              halted_o,
  output logic              glob_rst_o,
  output logic [NPORTS-1:0] port_rst_o
);
  logic [OFS_W-1:0]     ofs;
  logic                 wr_word, wr_byte;
  logic                 wr_cmd, wr_sts, wr_ien, wr_fnum, wr_blo, wr_bhi, wr_sof;
  logic                 ctl_clr, glob_req, wake;
  logic                 glob_q;
  logic [NPORTS-1:0]    wr_port;
  logic [CMD_W-1:0]     cmd;
  logic [STS_W-1:0]     sts;
  logic [IEN_W-1:0]     ien;
  logic [FNUM_W-1:0]    fnum;
  logic [FBASE_W-1:0]   fbase;
  logic [SOF_W-1:0]     sof;
  logic [NPORTS*DW-1:0] port_ctl;

  if (ADDR_W > OFS_W) begin : g_addr_hi
    logic unused_addr_hi;
    assign unused_addr_hi = ^addr_i[ADDR_W-1:OFS_W];
  end

  assign ofs      = addr_i[OFS_W-1:0];
  assign wr_word  = req_i & we_i & ~byte_i;
  assign wr_byte  = req_i & we_i & byte_i;
  assign wr_cmd   = wr_word & (ofs == OFS_CMD);
  assign wr_sts   = wr_word & (ofs == OFS_STS);
  assign wr_ien   = wr_word & (ofs == OFS_IEN);
  assign wr_fnum  = wr_word & (ofs == OFS_FNUM);
  assign wr_blo   = wr_word & (ofs == OFS_FBLO);
  assign wr_bhi   = wr_word & (ofs == OFS_FBHI);
  assign wr_sof   = wr_byte & (ofs == OFS_SOF);
  assign glob_req = wr_cmd & wdata_i[C_GRST];
  assign ctl_clr  = wr_cmd & (wdata_i[C_GRST] | wdata_i[C_HRST]);
  assign wake     = |{attach_i, detach_i};

  uhc_ctl u_ctl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (ctl_clr),
    .wr_cmd_i (wr_cmd),
    .wr_sts_i (wr_sts),
    .wr_ien_i (wr_ien),
    .wdata_i  (wdata_i[CMD_W-1:0]),
    .evt_i    (evt_i),
    .wake_i   (wake),
    .cmd_o    (cmd),
    .sts_o    (sts),
    .ien_o    (ien),
    .irq_o    (irq_o)
  );

  uhc_frm u_frm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (ctl_clr),
    .wr_fnum_i (wr_fnum),
    .wr_blo_i  (wr_blo),
    .wr_bhi_i  (wr_bhi),
    .wr_sof_i  (wr_sof),
    .wdata_i   (wdata_i),
    .fnum_o    (fnum),
    .fbase_o   (fbase),
    .sof_o     (sof)
  );

  for (genvar g = 0; g < NPORTS; g++) begin : g_port
    assign wr_port[g] = wr_word & ofs[4] & (ofs[3:1] == 3'(g));
    uhc_port u_port (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .clr_i       (ctl_clr),
      .glob_i      (glob_req),
      .wr_i        (wr_port[g]),
      .wdata_i     (wdata_i),
      .attach_i    (attach_i[g]),
      .detach_i    (detach_i[g]),
      .ls_i        (low_speed_i[g]),
      .ctl_o       (port_ctl[g*DW +: DW]),
      .rst_pulse_o (port_rst_o[g])
    );
  end

  uhc_rdmux #(.NPORTS(NPORTS)) u_rdmux (
    .byte_i  (byte_i),
    .ofs_i   (ofs),
    .cmd_i   (cmd),
    .sts_i   (sts),
    .ien_i   (ien),
    .fnum_i  (fnum),
    .fbase_i (fbase),
    .sof_i   (sof),
    .ports_i (port_ctl),
    .rdata_o (rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) glob_q <= 1'b0;
    else         glob_q <= glob_req;
  end

  assign glob_rst_o = glob_q;
  assign run_o      = cmd[C_RUN];
  assign halted_o   = sts[S_HALT];

  a_r4_glob_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    glob_req |=> (glob_rst_o && cmd == '0 && halted_o));
  a_r4_hc_no_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cmd && wdata_i[C_HRST] && !wdata_i[C_GRST]) |=> (!glob_rst_o && port_rst_o == '0));
endmodule

// File: tb/tb_uhc_regs.sv
module tb_uhc_regs;
  localparam int unsigned NP = 2;
  localparam int NV = 39;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, we = 1'b0, byt = 1'b0;
  logic [7:0]    addr = '0;
  logic [15:0]   wdata = '0;
  logic [15:0]   rdata;
  logic [2:0]    evt = '0;
  logic [NP-1:0] att = '0, det = '0, ls = '0;
  logic          irq, run, halted, grst;
  logic [NP-1:0] prst;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  uhc_regs #(.NPORTS(NP), .ADDR_W(8)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .byte_i(byt),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .evt_i(evt),
    .attach_i(att), .detach_i(det), .low_speed_i(ls),
    .irq_o(irq), .run_o(run), .halted_o(halted),
    .glob_rst_o(grst), .port_rst_o(prst)
  );

  // {write, byte, addr[7:0], data_or_expected[15:0]}
  localparam logic [25:0] VEC [0:NV-1] = '{
    {1'b0, 1'b0, 8'h00, 16'h0000},  // R2 command
    {1'b0, 1'b0, 8'h02, 16'h0020},  // R2 status
    {1'b0, 1'b0, 8'h04, 16'h0000},  // R2 enable
    {1'b0, 1'b1, 8'h0C, 16'h0040},  // R1 R2 sof byte
    {1'b0, 1'b1, 8'h00, 16'h00FF},  // R1 byte default
    {1'b0, 1'b0, 8'h0E, 16'h00FF},  // R1 word unmapped
    {1'b0, 1'b0, 8'h10, 16'h0080},  // R2 port0
    {1'b0, 1'b0, 8'h12, 16'h0080},  // R2 port1
    {1'b0, 1'b0, 8'h14, 16'h00FF},  // R5 port index 2
    {1'b1, 1'b0, 8'h26, 16'hFFFF},  // R1 R12 aliased frame number
    {1'b0, 1'b0, 8'h06, 16'h07FF},
    {1'b1, 1'b0, 8'h08, 16'hABCD},  // R12 base low
    {1'b0, 1'b0, 8'h08, 16'hA000},
    {1'b1, 1'b0, 8'h0A, 16'h1234},  // R12 base high
    {1'b0, 1'b0, 8'h2A, 16'h1234},
    {1'b1, 1'b1, 8'h0C, 16'h005A},  // R12 sof byte
    {1'b0, 1'b1, 8'h2C, 16'h005A},
    {1'b1, 1'b1, 8'h04, 16'h000F},  // R1 ignored byte write
    {1'b0, 1'b0, 8'h04, 16'h0000},
    {1'b1, 1'b0, 8'h04, 16'h00FF},  // R11 width of enable
    {1'b0, 1'b0, 8'h04, 16'h000F},
    {1'b1, 1'b0, 8'h00, 16'h0001},  // R3 run
    {1'b0, 1'b0, 8'h02, 16'h0000},
    {1'b0, 1'b0, 8'h00, 16'h0001},
    {1'b1, 1'b0, 8'h00, 16'h0000},  // R3 stop
    {1'b0, 1'b0, 8'h02, 16'h0020},
    {1'b1, 1'b0, 8'h12, 16'hFFFF},  // R6 keep mask
    {1'b0, 1'b0, 8'h12, 16'hFE84},
    {1'b1, 1'b0, 8'h12, 16'h0000},
    {1'b0, 1'b0, 8'h12, 16'h0080},
    {1'b1, 1'b0, 8'h16, 16'hFFFF},  // R5 ignored port write
    {1'b0, 1'b0, 8'h10, 16'h0080},
    {1'b0, 1'b0, 8'h12, 16'h0080},
    {1'b1, 1'b0, 8'h00, 16'h0002},  // R4 controller reset
    {1'b0, 1'b0, 8'h06, 16'h0000},
    {1'b0, 1'b0, 8'h08, 16'h0000},
    {1'b0, 1'b0, 8'h0A, 16'h0000},
    {1'b0, 1'b1, 8'h0C, 16'h0040},
    {1'b0, 1'b0, 8'h04, 16'h0000}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic b, input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; byt = b; addr = a; wdata = d;
    @(posedge clk); #1;
    req = 1'b0; we = 1'b0; byt = 1'b0;
  endtask

  task automatic rd(input string tag, input logic b, input logic [7:0] a, input logic [15:0] exp);
    byt = b; addr = a;
    #1;
    chk(tag, rdata, exp);
    byt = 1'b0;
  endtask

  task automatic pev(input logic [NP-1:0] a, input logic [NP-1:0] d,
                     input logic [NP-1:0] s, input logic [2:0] e);
    @(negedge clk);
    att = a; det = d; ls = s; evt = e;
    @(posedge clk); #1;
    att = '0; det = '0; evt = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    chk("R2 run_o", {15'b0, run}, 16'h0000);
    chk("R2 halted_o", {15'b0, halted}, 16'h0001);
    chk("R2 irq_o", {15'b0, irq}, 16'h0000);
    chk("R2 strobes", {13'b0, grst, prst}, 16'h0000);

    for (int k = 0; k < NV; k++) begin
      if (VEC[k][25]) wr(VEC[k][24], VEC[k][23:16], VEC[k][15:0]);
      else rd($sformatf("table %0d", k), VEC[k][24], VEC[k][23:16], VEC[k][15:0]);
    end

    // R3 run/halt outputs
    wr(1'b0, 8'h00, 16'h0001);
    chk("R3 run_o set", {15'b0, run}, 16'h0001);
    chk("R3 halted_o clr", {15'b0, halted}, 16'h0000);
    wr(1'b0, 8'h00, 16'h0001);
    chk("R3 halted_o stays", {15'b0, halted}, 16'h0000);
    wr(1'b0, 8'h00, 16'h0000);
    chk("R3 halted_o set", {15'b0, halted}, 16'h0001);

    // R8 attach low speed
    pev(2'b01, 2'b00, 2'b01, 3'b000);
    rd("R8 attach", 1'b0, 8'h10, 16'h0183);
    wr(1'b0, 8'h10, 16'h0002);
    rd("R6 clear CSC", 1'b0, 8'h10, 16'h0181);
    wr(1'b0, 8'h10, 16'h0004);
    rd("R6 enable", 1'b0, 8'h10, 16'h0185);

    // R7 port reset strobe
    wr(1'b0, 8'h10, 16'h0204);
    chk("R7 pulse", {14'b0, prst}, 16'h0001);
    rd("R7 reset bit", 1'b0, 8'h10, 16'h0385);
    @(posedge clk); #1;
    chk("R7 pulse ends", {14'b0, prst}, 16'h0000);
    wr(1'b0, 8'h10, 16'h0204);
    chk("R7 no repeat", {14'b0, prst}, 16'h0000);
    wr(1'b0, 8'h10, 16'h0004);
    rd("R6 reset bit clr", 1'b0, 8'h10, 16'h0185);

    // R8 detach enabled port
    pev(2'b00, 2'b01, 2'b00, 3'b000);
    rd("R8 detach", 1'b0, 8'h10, 16'h018A);

    // R8 vs R6: attach in same cycle as clear-by-one write
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 8'h10; wdata = 16'h000A; att = 2'b01; ls = 2'b00;
    @(posedge clk); #1;
    req = 1'b0; we = 1'b0; att = '0;
    rd("R8 event over write", 1'b0, 8'h10, 16'h0083);

    // R9 resume while suspended
    wr(1'b0, 8'h00, 16'h0008);
    pev(2'b10, 2'b00, 2'b00, 3'b000);
    rd("R9 force resume", 1'b0, 8'h00, 16'h0018);
    rd("R9 resume detect", 1'b0, 8'h02, 16'h0024);
    rd("R8 port1 attach", 1'b0, 8'h12, 16'h0083);
    chk("R11 masked", {15'b0, irq}, 16'h0000);
    wr(1'b0, 8'h04, 16'h0002);
    chk("R11 resume irq", {15'b0, irq}, 16'h0001);
    wr(1'b0, 8'h02, 16'h0004);
    rd("R10 w1c resume", 1'b0, 8'h02, 16'h0020);
    chk("R11 irq drops", {15'b0, irq}, 16'h0000);

    // R10: clear and set in same cycle
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 8'h02; wdata = 16'h0004; det = 2'b10;
    @(posedge clk); #1;
    req = 1'b0; we = 1'b0; det = '0;
    rd("R10 set wins", 1'b0, 8'h02, 16'h0024);
    rd("R8 port1 detach", 1'b0, 8'h12, 16'h0082);
    wr(1'b0, 8'h02, 16'h0004);

    // R9 negative: no suspend
    wr(1'b0, 8'h00, 16'h0000);
    pev(2'b10, 2'b00, 2'b00, 3'b000);
    rd("R9 no resume cmd", 1'b0, 8'h00, 16'h0000);
    rd("R9 no resume sts", 1'b0, 8'h02, 16'h0020);

    // R10/R11 schedule events
    pev(2'b00, 2'b00, 2'b00, 3'b001);
    rd("R10 done set", 1'b0, 8'h02, 16'h0021);
    chk("R11 done masked", {15'b0, irq}, 16'h0000);
    wr(1'b0, 8'h04, 16'h0004);
    chk("R11 done irq", {15'b0, irq}, 16'h0001);
    wr(1'b0, 8'h02, 16'h0001);
    chk("R11 done cleared", {15'b0, irq}, 16'h0000);
    pev(2'b00, 2'b00, 2'b00, 3'b100);
    rd("R10 perr set", 1'b0, 8'h02, 16'h0030);
    wr(1'b0, 8'h04, 16'h0008);
    chk("R11 perr irq", {15'b0, irq}, 16'h0001);
    pev(2'b00, 2'b00, 2'b00, 3'b010);
    wr(1'b0, 8'h04, 16'h0001);
    chk("R11 err irq", {15'b0, irq}, 16'h0001);
    wr(1'b0, 8'h02, 16'h0012);
    rd("R10 multi clear", 1'b0, 8'h02, 16'h0020);
    chk("R11 all clear", {15'b0, irq}, 16'h0000);

    // R4 global reset with one port connected
    pev(2'b00, 2'b10, 2'b00, 3'b000);
    wr(1'b0, 8'h00, 16'h0005);
    chk("R4 glob strobe", {15'b0, grst}, 16'h0001);
    chk("R4 port strobes", {14'b0, prst}, 16'h0001);
    chk("R4 halted", {15'b0, halted}, 16'h0001);
    rd("R4 cmd cleared", 1'b0, 8'h00, 16'h0000);
    rd("R4 port0 kept", 1'b0, 8'h10, 16'h0081);
    rd("R4 port1 reset", 1'b0, 8'h12, 16'h0080);
    @(posedge clk); #1;
    chk("R4 strobes end", {13'b0, grst, prst}, 16'h0000);

    // R4 controller reset: no strobes
    wr(1'b0, 8'h00, 16'h0003);
    chk("R4 hc no strobe", {13'b0, grst, prst}, 16'h0000);
    chk("R4 hc run_o", {15'b0, run}, 16'h0000);

    finish_run();
  end
endmodule